// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds eight independent lock tokens that two processor-facing ports, a left one and a right one, use to coordinate exclusive use of shared resources. Each port picks one token with a 3-bit index. It asks for that token by writing a 0 and gives it back by writing a 1. Either port may read any token at any time. The value it reads is the status of that token as seen from that port, copied onto all eight data bits.

A request for a token that the other port already holds does not fail. It is remembered. When the holder gives the token back, the waiting port becomes the owner in the same clock edge, and no other port can take the token in between. Because each port reads its own view, a port reads 0 only for a token it actually owns. Both ports read 1 for a token that is free or that the other port owns.

Reset is asynchronous and active low. It is released synchronously through a two-stage synchronizer. After reset every token is free and no request is pending.

Top module: `semflag_unit`

## Requirements
- R1: After reset all eight tokens are free with no pending requests, and both read-data outputs are 8'hFF.
- R2: The 3-bit index selects exactly one of eight tokens. A write to one token leaves the ownership seen on every other token unchanged.
- R3: A port that writes 0 (write data bit = 0) to a free token becomes its owner. A later read by that port returns 0, and a read by the other port returns 1.
- R4: A read returns the selected token's status for the reading port, replicated on all eight data bits: 8'h00 when the reader owns it, 8'hFF otherwise.
- R5: A 0 written by a port to a token the other port holds leaves the status unchanged: the holder still reads 0 and the writer reads 1.
- R6: When the holder writes 1 while the other port has a pending request, ownership passes directly to the other port, which then reads 0 while the former holder reads 1.
- R7: When the holder writes 1 with no request pending, the token becomes free and both ports read 1.
- R8: A 1 written by the port that does not hold the token leaves the holder's ownership unchanged and cancels any pending request of the writing port.
- R9: When both ports write 0 to a free token in the same cycle, the left port becomes the owner and the right port's request stays pending.
- R10: Write and read strobes have no effect unless the port's select input is high.
- R11: Read data is registered. It shows the status from before the clock edge at which a selected read strobe is sampled, and it holds its value while no selected read strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_sel | input | 1 | Left port select |
| lp_addr | input | 3 | Left port token index |
| lp_wr | input | 1 | Left port write strobe |
| lp_wbit | input | 1 | Left port write data (0 = request, 1 = release) |
| lp_rd | input | 1 | Left port read strobe |
| lp_rdata | output | 8 | Left port read data (status replicated) |
| rp_sel | input | 1 | Right port select |
| rp_addr | input | 3 | Right port token index |
| rp_wr | input | 1 | Right port write strobe |
| rp_wbit | input | 1 | Right port write data (0 = request, 1 = release) |
| rp_rd | input | 1 | Right port read strobe |
| rp_rdata | output | 8 | Right port read data (status replicated) |

## Verification
The bench targets the hand-off of a blocked request. A design that drops the request leaves the token free after the release, and the waiting port reads 1 where it should read 0. It also tests a non-owner's release write. A design that lets that write clear the owner, or that keeps the writer's own pending request, either frees a held token or hands it over later by surprise. Simultaneous requests to a free token must go to the left port with the right one queued, so a design without the tie rule shows the wrong owner or loses the right request. Writes without select, writes to neighbouring indices and reads without a strobe must leave every observed value untouched.

// File: rtl/semflag_pkg.sv
package semflag_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;
endpackage

// File: rtl/semflag_decode.sv
module semflag_decode #(
  parameter int NUM_FLAGS = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic                 wbit,
  output logic [NUM_FLAGS-1:0] req_vec,
  output logic [NUM_FLAGS-1:0] rel_vec
);
  logic wr_en;

  assign wr_en = sel & wr;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_dec
    logic hit;
    assign hit        = wr_en & (addr == ADDR_W'(g));
    assign req_vec[g] = hit & ~wbit;
    assign rel_vec[g] = hit &  wbit;
  end

  // R2: one write strobe reaches at most one token
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_vec | rel_vec));

  // R10: nothing reaches any token without select
  p_sel_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> ((req_vec | rel_vec) == '0));
endmodule

// File: rtl/semflag_cell.sv
module semflag_cell
  import semflag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic own_l,
  output logic own_r
);
  owner_e owner_q, owner_d;
  logic   pend_l_q, pend_l_d;
  logic   pend_r_q, pend_r_d;
  logic   upd_en;

  assign upd_en = req_l | rel_l | req_r | rel_r;

  always_comb begin
    owner_d  = owner_q;
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (req_l) begin
          owner_d  = OWN_LEFT;
          pend_r_d = req_r;
          pend_l_d = 1'b0;
        end else if (req_r) begin
          owner_d  = OWN_RIGHT;
          pend_l_d = 1'b0;
          pend_r_d = 1'b0;
        end
      end
      OWN_LEFT: begin
        if (rel_l) begin
          if ((pend_r_q | req_r) & ~rel_r) begin
            owner_d  = OWN_RIGHT;
          end else begin
            owner_d  = OWN_NONE;
          end
          pend_r_d = 1'b0;
          pend_l_d = 1'b0;
        end else begin
          if (rel_r)      pend_r_d = 1'b0;
          else if (req_r) pend_r_d = 1'b1;
        end
      end
      OWN_RIGHT: begin
        if (rel_r) begin
          if ((pend_l_q | req_l) & ~rel_l) begin
            owner_d  = OWN_LEFT;
          end else begin
            owner_d  = OWN_NONE;
          end
          pend_l_d = 1'b0;
          pend_r_d = 1'b0;
        end else begin
          if (rel_l)      pend_l_d = 1'b0;
          else if (req_l) pend_l_d = 1'b1;
        end
      end
      default: begin
        owner_d  = OWN_NONE;
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else if (upd_en) begin
      owner_q  <= owner_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign own_l = (owner_q == OWN_LEFT);
  assign own_r = (owner_q == OWN_RIGHT);

  // R5: the holder cannot also be waiting
  p_no_self_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l |-> !pend_l_q) and (own_r |-> !pend_r_q));

  // R5: a holder keeps the token until it releases
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l && !rel_l) |=> own_l);

  // R6: release with a waiter hands over at once
  p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l && rel_l && pend_r_q && !rel_r) |=> own_r);

  // R7: release with nobody waiting frees the token
  p_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_r && rel_r && !pend_l_q && !req_l) |=> (!own_l && !own_r));

  // R9: tie on a free token goes left, right stays queued
  p_tie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_l && !own_r && req_l && req_r) |=> (own_l && pend_r_q));

  // R8: a non-owner release drops that port's own wait
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l && rel_r && !rel_l) |=> (own_l && !pend_r_q));
endmodule

// File: rtl/semflag_view.sv
module semflag_view #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_FLAGS-1:0] mine_vec,
  output logic [DATA_W-1:0]    rdata
);
  logic              rd_en;
  logic [DATA_W-1:0] rdata_d;

  assign rd_en = sel & rd;

  always_comb begin
    rdata_d = {DATA_W{~mine_vec[addr]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '1;
    end else if (rd_en) begin
      rdata <= rdata_d;
    end
  end

  // R4: read data is always a replicated status bit
  p_replicated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata == '0) || (rdata == '1));

  // R11: read data holds without a selected read
  p_hold_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/semflag_unit.sv
module semflag_unit #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_sel,
  input  logic [ADDR_W-1:0] lp_addr,
  input  logic              lp_wr,
  input  logic              lp_wbit,
  input  logic              lp_rd,
  output logic [DATA_W-1:0] lp_rdata,
  input  logic              rp_sel,
  input  logic [ADDR_W-1:0] rp_addr,
  input  logic              rp_wr,
  input  logic              rp_wbit,
  input  logic              rp_rd,
  output logic [DATA_W-1:0] rp_rdata
);
  logic [1:0]           rst_pipe_q;
  logic                 rst_int_n;
  logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_FLAGS-1:0] l_own, r_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  semflag_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_l (
    .clk(clk), .rst_n(rst_int_n), .sel(lp_sel), .addr(lp_addr),
    .wr(lp_wr), .wbit(lp_wbit), .req_vec(l_req), .rel_vec(l_rel));

  semflag_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_r (
    .clk(clk), .rst_n(rst_int_n), .sel(rp_sel), .addr(rp_addr),
    .wr(rp_wr), .wbit(rp_wbit), .req_vec(r_req), .rel_vec(r_rel));

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
    semflag_cell u_cell (
      .clk(clk), .rst_n(rst_int_n),
      .req_l(l_req[g]), .rel_l(l_rel[g]),
      .req_r(r_req[g]), .rel_r(r_rel[g]),
      .own_l(l_own[g]), .own_r(r_own[g]));
  end

  semflag_view #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_view_l (
    .clk(clk), .rst_n(rst_int_n), .sel(lp_sel), .rd(lp_rd),
    .addr(lp_addr), .mine_vec(l_own), .rdata(lp_rdata));

  semflag_view #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_view_r (
    .clk(clk), .rst_n(rst_int_n), .sel(rp_sel), .rd(rp_rd),
    .addr(rp_addr), .mine_vec(r_own), .rdata(rp_rdata));

  // R3: no token is ever owned by both ports
  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (l_own & r_own) == '0);

  // R1: first cycle out of reset has no owners
  p_reset_free_r1: assert property (@(posedge clk)
    (rst_int_n && !$past(rst_int_n)) |-> ((l_own | r_own) == '0));
endmodule

// File: tb/sim_semflag_unit.sv
module sim_semflag_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lp_sel, lp_wr, lp_wbit, lp_rd;
  logic [2:0] lp_addr;
  logic [7:0] lp_rdata;
  logic       rp_sel, rp_wr, rp_wbit, rp_rd;
  logic [2:0] rp_addr;
  logic [7:0] rp_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  semflag_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .lp_sel(lp_sel), .lp_addr(lp_addr), .lp_wr(lp_wr), .lp_wbit(lp_wbit),
    .lp_rd(lp_rd), .lp_rdata(lp_rdata),
    .rp_sel(rp_sel), .rp_addr(rp_addr), .rp_wr(rp_wr), .rp_wbit(rp_wbit),
    .rp_rd(rp_rd), .rp_rdata(rp_rdata));

  // vector: [15] port (0 left,1 right) [14:13] op (1 write, 2 read)
  //         [12:10] index [9] write bit [8] expected bit [7:0] requirement
  function automatic logic [15:0] mk(input logic p, input logic [1:0] op,
      input logic [2:0] a, input logic wb, input logic ex, input int rq);
    return {p, op, a, wb, ex, 8'(rq)};
  endfunction

  localparam int NV = 26;
  localparam logic [15:0] VEC [0:NV-1] = '{
    mk(0, 2, 2, 0, 1, 1),   // R1 left sees free
    mk(1, 2, 2, 0, 1, 1),   // R1 right sees free
    mk(0, 1, 2, 0, 0, 3),   // left requests token 2
    mk(0, 2, 2, 0, 0, 3),   // R3 left owns
    mk(1, 2, 2, 0, 1, 3),   // R3 right does not
    mk(1, 1, 2, 0, 0, 5),   // right blocked, pending
    mk(1, 2, 2, 0, 1, 5),   // R5 right still 1
    mk(0, 2, 2, 0, 0, 5),   // R5 left still owns
    mk(0, 1, 2, 1, 0, 6),   // left releases
    mk(1, 2, 2, 0, 0, 6),   // R6 right now owns
    mk(0, 2, 2, 0, 1, 6),   // R6 left lost it
    mk(0, 1, 2, 1, 0, 8),   // left non-owner writes 1
    mk(1, 2, 2, 0, 0, 8),   // R8 right keeps it
    mk(1, 1, 2, 1, 0, 7),   // right releases, nobody waiting
    mk(0, 2, 2, 0, 1, 7),   // R7 free for left
    mk(1, 2, 2, 0, 1, 7),   // R7 free for right
    mk(1, 1, 5, 0, 0, 8),   // right takes token 5
    mk(0, 1, 5, 0, 0, 8),   // left queues
    mk(0, 1, 5, 1, 0, 8),   // left cancels own wait
    mk(1, 1, 5, 1, 0, 8),   // right releases
    mk(0, 2, 5, 0, 1, 8),   // R8 no hand-off after cancel
    mk(1, 2, 5, 0, 1, 8),   // R8 token 5 free
    mk(0, 1, 7, 0, 0, 2),   // left takes token 7
    mk(0, 2, 6, 0, 1, 2),   // R2 neighbour 6 untouched
    mk(1, 2, 0, 0, 1, 2),   // R2 token 0 untouched
    mk(0, 2, 7, 0, 0, 2)    // R2 token 7 owned
  };

  task automatic idle();
    lp_sel = 0; lp_wr = 0; lp_wbit = 0; lp_rd = 0; lp_addr = '0;
    rp_sel = 0; rp_wr = 0; rp_wbit = 0; rp_rd = 0; rp_addr = '0;
  endtask

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // one operation, strobe held across one rising edge
  task automatic op(input logic p, input logic [1:0] o, input logic [2:0] a, input logic wb);
    @(negedge clk);
    if (!p) begin
      lp_sel = 1; lp_addr = a; lp_wr = (o == 1); lp_wbit = wb; lp_rd = (o == 2);
    end else begin
      rp_sel = 1; rp_addr = a; rp_wr = (o == 1); rp_wbit = wb; rp_rd = (o == 2);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(input logic p, input logic [2:0] a, input logic ex, input string rq);
    op(p, 2, a, 0);
    check(rq, p ? rp_rdata : lp_rdata, {8{ex}});
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    idle();
    do_reset();
    check("R1 left", lp_rdata, 8'hFF);
    check("R1 right", rp_rdata, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      op(v[15], v[14:13], v[12:10], v[9]);
      if (v[14:13] == 2)
        check($sformatf("R%0d vec %0d", v[7:0], i), v[15] ? rp_rdata : lp_rdata, {8{v[8]}});
    end

    // R9: simultaneous requests on free token 3
    @(negedge clk);
    lp_sel = 1; lp_addr = 3; lp_wr = 1; lp_wbit = 0;
    rp_sel = 1; rp_addr = 3; rp_wr = 1; rp_wbit = 0;
    @(negedge clk);
    idle();
    rd_chk(0, 3, 0, "R9 left wins");
    rd_chk(1, 3, 1, "R9 right waits");
    op(0, 1, 3, 1);
    rd_chk(1, 3, 0, "R9 right pending granted");

    // R10: strobes without select
    @(negedge clk);
    lp_addr = 4; lp_wr = 1; lp_wbit = 0;
    @(negedge clk);
    idle();
    rd_chk(0, 4, 1, "R10 unselected write ignored");
    rd_chk(1, 4, 1, "R10 right also free");
    @(negedge clk);
    lp_addr = 7; lp_rd = 1;
    @(negedge clk);
    idle();
    check("R10 unselected read ignored", lp_rdata, 8'hFF);

    // R11: hold and pre-edge status
    rd_chk(0, 7, 0, "R11 owned read");
    repeat (3) @(negedge clk);
    check("R11 holds without strobe", lp_rdata, 8'h00);
    @(negedge clk);
    lp_sel = 1; lp_addr = 7; lp_rd = 1; lp_wr = 1; lp_wbit = 1;
    @(negedge clk);
    idle();
    check("R11 read shows pre-edge status", lp_rdata, 8'h00);
    rd_chk(0, 7, 1, "R11 release seen next read");

    // R1: reset clears ownership
    op(1, 1, 6, 0);
    do_reset();
    rd_chk(1, 6, 1, "R1 reset frees token");
    rd_chk(1, 3, 1, "R1 reset frees token 3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule